// File: doc/BRIEF.md
# Multi-Mode Serial Port

The block is a single serial port whose operating mode is picked by a two-bit mode input. Two of the modes are clocked (synchronous) byte transfers: as master it makes the shift clock from the system clock and drives it out; as slave it takes the shift clock from outside and drives an active-low ready line telling the remote master that a byte is waiting. The other two modes are start/stop framed (asynchronous) links carrying 7 or 8 data bits, with an optional parity bit that can be even or odd. One data-in pin and one data-out pin serve every mode.

Bytes to send enter through a valid/ready stream. A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while a byte is in flight, and in slave mode also while a loaded byte waits for the master. Received bytes leave through a second valid/ready stream backed by a one-entry holding register. `rx_data` does not change while `rx_valid` is high and `rx_ready` is low. A byte that completes while the holding register is full and not being read is discarded.

An internal tick runs every `(div_val+1) << clk_sel` system clocks. In master mode one tick is a half period of the shift clock. In the framed modes one tick is one sixteenth of a bit. Status flags for "transfer done", parity error and framing error stay set until `flag_clr` is pulsed.

Top module: `duo_serial_port`

## Requirements
- R1: After reset: `sdo` is 1, `sclk_oe` is 0, `rdy_n` is 1, `rx_valid` is 0, and all three flags are 0.
- R2: In master mode (mode = 0), `sclk_oe` is 1. A transfer makes exactly 8 low pulses on `sclk_o`, with a period of 2·((div_val+1)<<clk_sel) system clocks. `sclk_o` rests high between transfers.
- R3: In the clocked modes, bits go out and come in least significant bit first. `sdo` changes only after a falling shift-clock edge, and `sdi` is sampled on rising edges. After the eighth rising edge the received byte is offered on the rx stream and `done_flag` is set.
- R4: In slave mode (mode = 1), `sclk_oe` is 0 and `sclk_i` alone paces the shift, whatever `clk_sel` holds. `sclk_oe` is 0 in every mode except master.
- R5: `rdy_n` goes low only in slave mode, once a byte has been loaded while enabled. It returns high at the first falling edge on `sclk_i` and stays high until the next byte is loaded. `rdy_n` stays high in the other modes.
- R6: A framed transmit (mode 2 = 7 data bits, mode 3 = 8 data bits) sends, in order: one low start bit, the data LSB first, the parity bit when enabled, and one high stop bit. Each bit lasts 16 ticks, and `sdo` idles high.
- R7: With `par_en`=1, the parity bit is the XOR of the data bits when `par_odd`=0 (even), and its complement when `par_odd`=1 (odd). With `par_en`=0 no parity bit is sent or expected.
- R8: The framed receiver finds a falling edge on `sdi`, confirms the start bit half a bit later, and samples each later bit at its middle. It delivers the data with unused upper bits zero, so in 7-bit mode bit 7 is 0.
- R9: A received parity mismatch sets `perr_flag`, and a low stop bit sets `ferr_flag`. The data byte is still delivered. Flags stay set until `flag_clr` is high on a clock edge.
- R10: `rx_data` is held stable while `rx_valid`=1 and `rx_ready`=0. A byte that completes while the holding register is full and not being read is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Port enable |
| mode | input | 2 | 0 master, 1 slave, 2 framed 7-bit, 3 framed 8-bit |
| clk_sel | input | 2 | Tick period shift (not used in slave mode) |
| div_val | input | DIV_W | Tick period base, tick every (div_val+1)<<clk_sel clocks |
| par_en | input | 1 | Parity bit enable in framed modes |
| par_odd | input | 1 | 1 odd parity, 0 even parity |
| flag_clr | input | 1 | Clears the sticky flags |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Port can take a byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data holds a byte |
| rx_ready | input | 1 | Consumer takes rx_data |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sclk_i | input | 1 | Shift clock from the pin (slave) |
| sclk_o | output | 1 | Shift clock to the pin (master) |
| sclk_oe | output | 1 | Drive enable for the shift-clock pin |
| rdy_n | output | 1 | Slave ready, active low |
| done_flag | output | 1 | Sticky: clocked transfer completed |
| perr_flag | output | 1 | Sticky: parity error |
| ferr_flag | output | 1 | Sticky: framing error |

## Verification
The embedded properties assume that the mode, divider, clock select and parity inputs do not change while a transfer is in progress. They also assume that a remote master driving `sclk_i` starts each byte with a falling edge and holds each level far longer than the two-stage input synchronizer delay. The bench changes configuration only between scenarios, after the port is idle. It drives `sclk_i` with half periods of ten system clocks and holds framed bits for exactly 16 ticks, so every sample point falls well inside a bit.

// File: rtl/dsp_pkg.sv
`timescale 1ns/1ps
package dsp_pkg;
  localparam int DATA_W = 8;
  localparam int OVS    = 16;

  typedef enum logic [1:0] {
    MODE_SYNC_MST = 2'd0,
    MODE_SYNC_SLV = 2'd1,
    MODE_ASYNC7   = 2'd2,
    MODE_ASYNC8   = 2'd3
  } mode_e;

  // even parity = XOR of the data bits in use; odd = its complement
  function automatic logic frame_parity(input logic [DATA_W-1:0] d,
                                        input logic wide, input logic odd);
    logic [DATA_W-1:0] m;
    m = d;
    if (!wide) m[DATA_W-1] = 1'b0;
    return (^m) ^ odd;
  endfunction
endpackage

// File: rtl/dsp_tick_gen.sv
`timescale 1ns/1ps
module dsp_tick_gen #(
  parameter int DIV_W = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  input  logic [SEL_W-1:0] clk_sel,
  output logic             tick
);
  localparam int CNT_W = DIV_W + (1 << SEL_W);

  logic [CNT_W-1:0] lim, cnt;

  assign lim = (CNT_W'(div_val) + CNT_W'(1)) << clk_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim - CNT_W'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CNT_W'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/dsp_sync_shift.sv
`timescale 1ns/1ps
module dsp_sync_shift
  import dsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              slave,
  input  logic              tick,
  input  logic              sdi,
  input  logic              sclk_i,
  input  logic              ld_valid,
  input  logic [DATA_W-1:0] ld_data,
  output logic              ld_ready,
  output logic              sdo,
  output logic              sclk_o,
  output logic              sclk_oe,
  output logic              rdy_n,
  output logic              rx_pulse,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CW = $clog2(DATA_W + 1);

  logic [2:0]        sclk_s;
  logic [1:0]        sdi_s;
  logic              busy, loaded, sclk_q;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] txsh, rxsh;
  logic              rise_ev, fall_ev, smp, s_rise, s_fall, load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '1;
      sdi_s  <= '1;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk_i};
      sdi_s  <= {sdi_s[0], sdi};
    end
  end

  assign s_rise = sclk_s[1] & ~sclk_s[2];
  assign s_fall = ~sclk_s[1] & sclk_s[2];

  always_comb begin
    if (slave) begin
      rise_ev = s_rise && busy;
      fall_ev = s_fall && (busy || loaded);
      smp     = sdi_s[1];
    end else begin
      rise_ev = busy && tick && !sclk_q;
      fall_ev = busy && tick && sclk_q;
      smp     = sdi;
    end
  end

  assign ld_ready = en && !busy && !loaded;
  assign load     = ld_valid && ld_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      loaded   <= 1'b0;
      sclk_q   <= 1'b1;
      cnt      <= '0;
      txsh     <= '1;
      rxsh     <= '0;
      rx_pulse <= 1'b0;
    end else begin
      rx_pulse <= 1'b0;
      if (!en) begin
        busy   <= 1'b0;
        loaded <= 1'b0;
        sclk_q <= 1'b1;
        cnt    <= '0;
        txsh   <= '1;
      end else begin
        if (load) begin
          txsh   <= ld_data;
          cnt    <= '0;
          sclk_q <= 1'b1;
          if (slave) loaded <= 1'b1;
          else       busy   <= 1'b1;
        end
        if (fall_ev) begin
          if (!slave) sclk_q <= 1'b0;
          if (loaded) begin
            loaded <= 1'b0;
            busy   <= 1'b1;
          end
          if (cnt != '0) txsh <= {1'b1, txsh[DATA_W-1:1]};
        end
        if (rise_ev) begin
          if (!slave) sclk_q <= 1'b1;
          rxsh <= {smp, rxsh[DATA_W-1:1]};
          if (cnt == CW'(DATA_W - 1)) begin
            busy     <= 1'b0;
            cnt      <= '0;
            rx_pulse <= 1'b1;
            txsh     <= '1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      end
    end
  end

  assign sdo     = txsh[0];
  assign sclk_o  = sclk_q;
  assign sclk_oe = en && !slave;
  assign rdy_n   = !(en && slave && loaded);
  assign rx_byte = rxsh;

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DATA_W - 1));
  p_done_after_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pulse |-> $past(rise_ev));
  p_idle_clock_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !slave && !busy) |-> sclk_o);
  p_rdy_drop_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && slave && !rdy_n && fall_ev) |=> rdy_n);
endmodule

// File: rtl/dsp_async_tx.sv
`timescale 1ns/1ps
module dsp_async_tx
  import dsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              wide,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              ld_valid,
  input  logic [DATA_W-1:0] ld_data,
  output logic              ld_ready,
  output logic              sdo
);
  localparam int PW = $clog2(DATA_W + 3);
  localparam int FL = 1 << PW;
  localparam int SW = $clog2(OVS);

  logic [FL-1:0] frame, fr;
  logic [PW-1:0] pos, last, flen_m1;
  logic [SW-1:0] sub;
  logic          busy, pbit, load;

  always_comb begin
    int nb;
    nb   = wide ? DATA_W : DATA_W - 1;
    pbit = frame_parity(ld_data, wide, par_odd);
    fr   = '1;
    fr[0] = 1'b0;
    for (int k = 0; k < DATA_W; k++)
      if (k < nb) fr[k+1] = ld_data[k];
    for (int k = 1; k < FL; k++)
      if (par_en && k == nb + 1) fr[k] = pbit;
    flen_m1 = PW'(nb + 1) + PW'(par_en);
  end

  assign ld_ready = en && !busy;
  assign load     = ld_valid && ld_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      frame <= '1;
      pos   <= '0;
      last  <= '0;
      sub   <= '0;
    end else if (!en) begin
      busy <= 1'b0;
    end else if (load) begin
      busy  <= 1'b1;
      frame <= fr;
      last  <= flen_m1;
      pos   <= '0;
      sub   <= '0;
    end else if (busy && tick) begin
      if (sub == SW'(OVS - 1)) begin
        sub <= '0;
        if (pos == last) busy <= 1'b0;
        else             pos  <= pos + PW'(1);
      end else begin
        sub <= sub + SW'(1);
      end
    end
  end

  assign sdo = busy ? frame[pos] : 1'b1;

  p_start_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pos == '0) |-> !sdo);
  p_stop_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pos == last) |-> sdo);
endmodule

// File: rtl/dsp_async_rx.sv
`timescale 1ns/1ps
module dsp_async_rx
  import dsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              wide,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              sdi,
  output logic              out_pulse,
  output logic [DATA_W-1:0] out_byte,
  output logic              perr_pulse,
  output logic              ferr_pulse
);
  localparam int SW = $clog2(OVS);
  localparam int IW = $clog2(DATA_W + 2);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_e;

  rx_st_e            st;
  logic [1:0]        sdi_s;
  logic              rxs, pbit;
  logic [SW-1:0]     sub;
  logic [IW-1:0]     idx, nb, last;
  logic [DATA_W-1:0] data;

  assign rxs  = sdi_s[1];
  assign nb   = wide ? IW'(DATA_W) : IW'(DATA_W - 1);
  assign last = nb + IW'(par_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sdi_s <= '1;
    else        sdi_s <= {sdi_s[0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= RX_IDLE;
      sub        <= '0;
      idx        <= '0;
      data       <= '0;
      pbit       <= 1'b0;
      out_pulse  <= 1'b0;
      perr_pulse <= 1'b0;
      ferr_pulse <= 1'b0;
    end else begin
      out_pulse  <= 1'b0;
      perr_pulse <= 1'b0;
      ferr_pulse <= 1'b0;
      if (!en) begin
        st <= RX_IDLE;
      end else if (tick) begin
        case (st)
          RX_IDLE: if (!rxs) begin
            st   <= RX_START;
            sub  <= '0;
            idx  <= '0;
            data <= '0;
          end
          RX_START: if (sub == SW'(OVS/2 - 1)) begin
            sub <= '0;
            st  <= rxs ? RX_IDLE : RX_BITS;
          end else begin
            sub <= sub + SW'(1);
          end
          RX_BITS: if (sub == SW'(OVS - 1)) begin
            sub <= '0;
            if (idx < nb) data[idx[IW-2:0]] <= rxs;
            else if (par_en && idx == nb) pbit <= rxs;
            if (idx == last) begin
              st         <= RX_IDLE;
              out_pulse  <= 1'b1;
              perr_pulse <= par_en && (pbit != frame_parity(data, wide, par_odd));
              ferr_pulse <= !rxs;
            end else begin
              idx <= idx + IW'(1);
            end
          end else begin
            sub <= sub + SW'(1);
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  assign out_byte = data;

  p_err_with_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_pulse || ferr_pulse) |-> out_pulse);
  p_narrow_top_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pulse && !wide) |-> !out_byte[DATA_W-1]);
endmodule

// File: rtl/duo_serial_port.sv
`timescale 1ns/1ps
module duo_serial_port
  import dsp_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic [SEL_W-1:0]  clk_sel,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              flag_clr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic              sdi,
  output logic              sdo,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  output logic              rdy_n,
  output logic              done_flag,
  output logic              perr_flag,
  output logic              ferr_flag
);
  mode_e             m;
  logic              sync_mode, tick;
  logic              s_ready, s_sdo, s_pulse;
  logic [DATA_W-1:0] s_byte;
  logic              a_ready, a_sdo, a_pulse, a_perr, a_ferr;
  logic [DATA_W-1:0] a_byte;
  logic              push;
  logic [DATA_W-1:0] push_byte;

  assign m         = mode_e'(mode);
  assign sync_mode = (m == MODE_SYNC_MST) || (m == MODE_SYNC_SLV);

  dsp_tick_gen #(.DIV_W(DIV_W), .SEL_W(SEL_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .run(en && m != MODE_SYNC_SLV),
    .div_val(div_val), .clk_sel(clk_sel), .tick(tick));

  dsp_sync_shift sync_i (
    .clk(clk), .rst_n(rst_n), .en(en && sync_mode), .slave(m == MODE_SYNC_SLV),
    .tick(tick), .sdi(sdi), .sclk_i(sclk_i),
    .ld_valid(tx_valid && sync_mode), .ld_data(tx_data), .ld_ready(s_ready),
    .sdo(s_sdo), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .rdy_n(rdy_n),
    .rx_pulse(s_pulse), .rx_byte(s_byte));

  dsp_async_tx atx_i (
    .clk(clk), .rst_n(rst_n), .en(en && !sync_mode), .tick(tick),
    .wide(m == MODE_ASYNC8), .par_en(par_en), .par_odd(par_odd),
    .ld_valid(tx_valid && !sync_mode), .ld_data(tx_data), .ld_ready(a_ready),
    .sdo(a_sdo));

  dsp_async_rx arx_i (
    .clk(clk), .rst_n(rst_n), .en(en && !sync_mode), .tick(tick),
    .wide(m == MODE_ASYNC8), .par_en(par_en), .par_odd(par_odd), .sdi(sdi),
    .out_pulse(a_pulse), .out_byte(a_byte), .perr_pulse(a_perr), .ferr_pulse(a_ferr));

  assign tx_ready  = sync_mode ? s_ready : a_ready;
  assign sdo       = sync_mode ? s_sdo : a_sdo;
  assign push      = sync_mode ? s_pulse : a_pulse;
  assign push_byte = sync_mode ? s_byte : a_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (push && (!rx_valid || rx_ready)) begin
      rx_valid <= 1'b1;
      rx_data  <= push_byte;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      perr_flag <= 1'b0;
      ferr_flag <= 1'b0;
    end else begin
      if (s_pulse && sync_mode) done_flag <= 1'b1;
      else if (flag_clr)        done_flag <= 1'b0;
      if (a_perr && !sync_mode) perr_flag <= 1'b1;
      else if (flag_clr)        perr_flag <= 1'b0;
      if (a_ferr && !sync_mode) ferr_flag <= 1'b1;
      else if (flag_clr)        ferr_flag <= 1'b0;
    end
  end

  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  p_perr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_flag && !flag_clr) |=> perr_flag);
  p_ferr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr_flag && !flag_clr) |=> ferr_flag);
  p_oe_master_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_oe |-> (m == MODE_SYNC_MST));
endmodule

// File: tb/duo_serial_port_tb_top.sv
`timescale 1ns/1ps
module duo_serial_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [1:0] clk_sel = 2'd0;
  logic [7:0] div_val = 8'd1;
  logic       par_en = 1'b0, par_odd = 1'b0, flag_clr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0, rx_ready = 1'b0;
  logic       sdi = 1'b1, sclk_i = 1'b1;
  logic       tx_ready, rx_valid, sdo, sclk_o, sclk_oe, rdy_n;
  logic       done_flag, perr_flag, ferr_flag;
  logic [7:0] rx_data;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  duo_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .clk_sel(clk_sel),
    .div_val(div_val), .par_en(par_en), .par_odd(par_odd), .flag_clr(flag_clr),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .sdi(sdi), .sdo(sdo), .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .rdy_n(rdy_n), .done_flag(done_flag), .perr_flag(perr_flag), .ferr_flag(ferr_flag));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop(output logic [7:0] d, output bit got);
    int w = 0;
    got = 1'b0;
    d = 8'h00;
    @(negedge clk);
    while (!rx_valid && w < 2000) begin @(negedge clk); w++; end
    if (rx_valid) begin
      got = 1'b1;
      d = rx_data;
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  function automatic logic par_of(input logic [7:0] d, input int nb, input logic odd);
    logic p = odd;
    for (int k = 0; k < nb; k++) p ^= d[k];
    return p;
  endfunction

  // R1
  task automatic t_reset();
    chk(sdo == 1'b1, "R1 sdo idle", sdo, 1);
    chk(sclk_oe == 1'b0, "R1 sclk_oe", sclk_oe, 0);
    chk(rdy_n == 1'b1, "R1 rdy_n", rdy_n, 1);
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    chk({done_flag, perr_flag, ferr_flag} == 3'b000, "R1 flags",
        {done_flag, perr_flag, ferr_flag}, 0);
  endtask

  // R2 R3: master transfer, bench acts as remote slave
  task automatic t_master();
    logic [7:0] got_out = 8'h00, rx;
    logic [7:0] remote = 8'h3C;
    realtime t1 = 0, t2 = 0;
    bit ok;
    mode = 2'd0; div_val = 8'd1; clk_sel = 2'd1;   // tick every 4 clocks
    clks(4);
    chk(sclk_oe == 1'b1, "R2 sclk_oe in master", sclk_oe, 1);
    fork
      push(8'hA5);
      for (int i = 0; i < 8; i++) begin
        @(negedge sclk_o); #1 sdi = remote[i];
        @(posedge sclk_o);
        if (i == 0) t1 = $realtime;
        if (i == 1) t2 = $realtime;
        #1 got_out[i] = sdo;
      end
    join
    chk(int'(t2 - t1) == 40, "R2 shift clock period ns", int'(t2 - t1), 40);
    pop(rx, ok);
    chk(ok && rx == remote, "R3 master received byte", rx, remote);
    chk(got_out == 8'hA5, "R3 master sent byte LSB first", got_out, 8'hA5);
    chk(done_flag == 1'b1, "R3 done flag", done_flag, 1);
    clks(20);
    chk(sclk_o == 1'b1, "R2 clock rests high", sclk_o, 1);
    pulse_clr();
    chk(done_flag == 1'b0, "R3 done flag cleared", done_flag, 0);
  endtask

  // R4 R5: slave transfer, bench acts as remote master
  task automatic t_slave();
    logic [7:0] got_out = 8'h00, rx;
    logic [7:0] remote = 8'hC3;
    bit ok;
    mode = 2'd1; clk_sel = 2'd3; sclk_i = 1'b1;   // clk_sel must not matter
    clks(4);
    chk(sclk_oe == 1'b0, "R4 sclk_oe in slave", sclk_oe, 0);
    chk(rdy_n == 1'b1, "R5 rdy_n before load", rdy_n, 1);
    push(8'h5A);
    clks(3);
    chk(rdy_n == 1'b0, "R5 rdy_n after load", rdy_n, 0);
    chk(tx_ready == 1'b0, "R10 tx_ready low while loaded", tx_ready, 0);
    for (int i = 0; i < 8; i++) begin
      sclk_i = 1'b0; sdi = remote[i];
      clks(10);
      if (i == 0) chk(rdy_n == 1'b1, "R5 rdy_n high after first edge", rdy_n, 1);
      got_out[i] = sdo;
      sclk_i = 1'b1;
      clks(10);
    end
    pop(rx, ok);
    chk(ok && rx == remote, "R4 slave received byte", rx, remote);
    chk(got_out == 8'h5A, "R4 slave sent byte", got_out, 8'h5A);
    chk(rdy_n == 1'b1, "R5 rdy_n after transfer", rdy_n, 1);
    pulse_clr();
  endtask

  // R6 R7: framed transmit check
  task automatic t_atx(input logic [1:0] md, input logic [7:0] d, input logic pe,
                       input logic odd, input string tag);
    int nb = (md == 2'd3) ? 8 : 7;
    logic [7:0] got = 8'h00;
    logic s, p, st;
    mode = md; par_en = pe; par_odd = odd; div_val = 8'd1; clk_sel = 2'd0;
    clks(4);
    chk(rdy_n == 1'b1 && sclk_oe == 1'b0, {tag, " R5 R4 pins idle in framed mode"},
        {rdy_n, sclk_oe}, 2);
    push(d);
    clks(16);
    s = sdo;
    for (int k = 0; k < nb; k++) begin clks(32); got[k] = sdo; end
    if (pe) begin clks(32); p = sdo; end
    clks(32); st = sdo;
    chk(s == 1'b0, {tag, " R6 start bit"}, s, 0);
    chk(got == (nb == 8 ? d : {1'b0, d[6:0]}), {tag, " R6 data bits"}, got, d);
    if (pe) chk(p == par_of(d, nb, odd), {tag, " R7 parity bit"}, p, par_of(d, nb, odd));
    chk(st == 1'b1, {tag, " R6 stop bit"}, st, 1);
    clks(40);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input logic pe,
                            input logic p, input logic stop);
    sdi = 1'b0; clks(32);
    for (int k = 0; k < nb; k++) begin sdi = d[k]; clks(32); end
    if (pe) begin sdi = p; clks(32); end
    sdi = stop; clks(32);
    sdi = 1'b1; clks(40);
  endtask

  // R8 R9 R10: framed receive
  task automatic t_arx();
    logic [7:0] rx;
    bit ok;
    mode = 2'd3; par_en = 1'b1; par_odd = 1'b0; sdi = 1'b1;
    clks(10);
    send_frame(8'h3B, 8, 1'b1, par_of(8'h3B, 8, 1'b0), 1'b1);
    pop(rx, ok);
    chk(ok && rx == 8'h3B, "R8 good frame data", rx, 8'h3B);
    chk(perr_flag == 1'b0 && ferr_flag == 1'b0, "R9 no error on good frame",
        {perr_flag, ferr_flag}, 0);
    send_frame(8'h3B, 8, 1'b1, ~par_of(8'h3B, 8, 1'b0), 1'b1);
    pop(rx, ok);
    chk(ok && rx == 8'h3B, "R9 data kept on parity error", rx, 8'h3B);
    chk(perr_flag == 1'b1, "R9 parity error flag", perr_flag, 1);
    send_frame(8'h81, 8, 1'b1, par_of(8'h81, 8, 1'b0), 1'b0);
    pop(rx, ok);
    chk(ferr_flag == 1'b1, "R9 framing error flag", ferr_flag, 1);
    clks(50);
    chk(perr_flag && ferr_flag, "R9 flags sticky", {perr_flag, ferr_flag}, 3);
    pulse_clr();
    chk(!perr_flag && !ferr_flag, "R9 flags cleared", {perr_flag, ferr_flag}, 0);
    mode = 2'd2; par_en = 1'b0;
    clks(10);
    send_frame(8'hD5, 7, 1'b0, 1'b0, 1'b1);
    pop(rx, ok);
    chk(ok && rx == 8'h55, "R8 7-bit frame, top bit zero", rx, 8'h55);
    mode = 2'd3;
    clks(10);
    send_frame(8'h11, 8, 1'b0, 1'b0, 1'b1);
    clks(5);
    chk(rx_valid && rx_data == 8'h11, "R10 held without ready", rx_data, 8'h11);
    send_frame(8'h22, 8, 1'b0, 1'b0, 1'b1);
    pop(rx, ok);
    chk(ok && rx == 8'h11, "R10 first byte kept", rx, 8'h11);
    clks(2);
    chk(rx_valid == 1'b0, "R10 byte arriving while full dropped", rx_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clks(5);
    t_reset();
    rst_n = 1'b1;
    clks(3);
    t_reset();
    en = 1'b1;
    t_master();
    t_slave();
    t_atx(2'd3, 8'h96, 1'b1, 1'b0, "8-bit even");
    t_atx(2'd2, 8'h25, 1'b1, 1'b1, "7-bit odd");
    t_atx(2'd3, 8'h6E, 1'b0, 1'b0, "8-bit none");
    t_arx();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule